// File: doc/BRIEF.md
# DMA Channel Register File with Byte-Serial Host Access

This block is the host-facing register file of a four-channel DMA controller that sits on an 8-bit I/O bus. The host selects one of sixteen port offsets. Each channel has a 16-bit address register, a 16-bit count register and a 6-bit mode field. A command register and a 4-bit request mask are shared by all channels. The transfer engine reads the settings from flat output vectors.

The 16-bit registers are reached one byte at a time. A single shared pointer flip-flop chooses between the low and the high byte, and every address or count access toggles it. Several offsets act as commands rather than storage:

- clear the pointer
- master clear
- set or clear one mask bit
- clear all masks

Each address or count byte written loads the base and current copies together. Reads return the current value.

Top module: `dma_host_regs`

## Requirements
- R1: After reset, all mask bits are 1, the command register is 0, `ctl_enable` is 1, the byte pointer selects the low byte, and every address, count and mode field is 0.
- R2: Offsets 0 to 7 reach channel `ofs[2:1]`. An even offset selects the address register and an odd offset selects the count register. The low byte is accessed first and then the high byte. Each access, read or write, toggles the byte pointer. A read returns the byte that the pointer selects.
- R3: An address or count write changes only the addressed register of the addressed channel.
- R4: Any write to offset 0xC returns the byte pointer to the low byte, whatever the data.
- R5: A write to offset 0xB picks the channel from data bits 1:0 and stores data bits 7:2 in that channel's 6-bit mode field. In that field, bits 1:0 are the transfer type (00 verify, 01 to memory, 10 from memory) and bits 5:4 are the mode (00 demand, 01 single, 10 block, 11 cascade). Other channels keep their mode.
- R6: A write to offset 0xA picks a channel from data bits 1:0. It sets that channel's mask bit when data bit 2 is 1 and clears it when data bit 2 is 0. The other mask bits do not change.
- R7: A write to offset 0xE clears all four mask bits.
- R8: A write to offset 0xF loads the mask from data bits 3:0. A read of offset 0xF returns the mask in bits 3:0 with zeros above.
- R9: A write to offset 0x8 loads the command register. `ctl_enable` is low exactly while command bit 2 is 1.
- R10: A write to offset 0xD gives the same state as reset: masks all set, command cleared, pointer on the low byte, and all address, count and mode fields at 0.
- R11: A read of any offset from 0x8 to 0xE returns 0 and leaves the byte pointer unchanged.
- R12: While `bus_sel` is low, reads and writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Block select for the current bus cycle |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe; the pointer side effect takes effect at the clock edge |
| bus_ofs | input | 4 | Port offset |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, combinational from the current state |
| ctl_cmd | output | 8 | Command register value |
| ctl_enable | output | 1 | Controller enable (low when command bit 2 is set) |
| chan_mask | output | 4 | Request mask, one bit per channel |
| chan_mode | output | 24 | Mode fields, 6 bits per channel, channel 0 in the lowest bits |
| chan_addr | output | 64 | Current address, 16 bits per channel |
| chan_count | output | 64 | Current count, 16 bits per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit address and count, and an 8-bit bus. This is the only combination that the fixed offset map supports. With these values every decoded offset exists, so each command port and both byte halves of every register can be reached.

The tests drive the pointer into the high state before a pointer clear and before a master clear. They also read the register ports and check that the pointer did not toggle, by reading a known address byte afterwards.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

   localparam logic [3:0] OFS_CMD       = 4'h8;
   localparam logic [3:0] OFS_MASK_ONE  = 4'hA;
   localparam logic [3:0] OFS_MODE      = 4'hB;
   localparam logic [3:0] OFS_PTR_CLR   = 4'hC;
   localparam logic [3:0] OFS_MASTER    = 4'hD;
   localparam logic [3:0] OFS_MASK_NONE = 4'hE;
   localparam logic [3:0] OFS_MASK_ALL  = 4'hF;

   // decoded strobes for one bus cycle
   typedef struct packed {
      logic       reg_wr;
      logic       reg_rd;
      logic [1:0] ch;
      logic       is_cnt;
      logic       cmd_wr;
      logic       mode_wr;
      logic       mask_bit_wr;
      logic       ptr_clr;
      logic       mclr;
      logic       mask_clr_all;
      logic       mask_ld;
      logic       mask_rd;
   } strobes_t;

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
   import dma_regs_pkg::*;
(
   input  logic       sel,
   input  logic       wr,
   input  logic       rd,
   input  logic [3:0] ofs,
   output strobes_t   st
);

   always_comb begin
      st        = '0;
      st.ch     = ofs[2:1];
      st.is_cnt = ofs[0];
      if (sel && !ofs[3]) begin
         st.reg_wr = wr;
         st.reg_rd = rd && !wr;
      end
      if (sel && wr) begin
         case (ofs)
            OFS_CMD:       st.cmd_wr       = 1'b1;
            OFS_MASK_ONE:  st.mask_bit_wr  = 1'b1;
            OFS_MODE:      st.mode_wr      = 1'b1;
            OFS_PTR_CLR:   st.ptr_clr      = 1'b1;
            OFS_MASTER:    st.mclr         = 1'b1;
            OFS_MASK_NONE: st.mask_clr_all = 1'b1;
            OFS_MASK_ALL:  st.mask_ld      = 1'b1;
            default:       ;
         endcase
      end
      st.mask_rd = sel && rd && !wr && (ofs == OFS_MASK_ALL);
   end

endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic hi
);

   always_ff @(posedge clk) begin
      if (!rst_n)    hi <= 1'b0;
      else if (clr)  hi <= 1'b0;
      else if (step) hi <= ~hi;
   end

   assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !hi);

   assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> (hi != $past(hi)));

   assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(hi));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned MODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclr,
   input  logic              hi,
   input  logic              wr_addr,
   input  logic              wr_cnt,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              mode_ld,
   input  logic [MODE_W-1:0] mode_in,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic [MODE_W-1:0] mode
);

   always_ff @(posedge clk) begin
      if (!rst_n || mclr) begin
         cur_addr <= '0;
         cur_cnt  <= '0;
         mode     <= '0;
      end else begin
         if (wr_addr) begin
            if (hi) cur_addr[ADDR_W-1:BUS_W] <= wdata;
            else    cur_addr[BUS_W-1:0]      <= wdata;
         end
         if (wr_cnt) begin
            if (hi) cur_cnt[CNT_W-1:BUS_W] <= wdata;
            else    cur_cnt[BUS_W-1:0]     <= wdata;
         end
         if (mode_ld) mode <= mode_in;
      end
   end

   assert_addr_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr && !hi && !mclr) |=>
         (cur_addr[BUS_W-1:0] == $past(wdata)) &&
         (cur_addr[ADDR_W-1:BUS_W] == $past(cur_addr[ADDR_W-1:BUS_W])));

   assert_cnt_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cnt && hi && !mclr) |=>
         (cur_cnt[CNT_W-1:BUS_W] == $past(wdata)) &&
         (cur_cnt[BUS_W-1:0] == $past(cur_cnt[BUS_W-1:0])));

   assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_addr && !wr_cnt && !mode_ld && !mclr) |=>
         $stable(cur_addr) && $stable(cur_cnt) && $stable(mode));

endmodule

// File: rtl/dma_mask_reg.sv
module dma_mask_reg #(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclr,
   input  logic              bit_wr,
   input  logic [CH_W-1:0]   bit_ch,
   input  logic              bit_val,
   input  logic              clr_all,
   input  logic              ld,
   input  logic [NUM_CH-1:0] ld_val,
   output logic [NUM_CH-1:0] mask
);

   always_ff @(posedge clk) begin
      if (!rst_n || mclr)  mask         <= '1;
      else if (clr_all)    mask         <= '0;
      else if (ld)         mask         <= ld_val;
      else if (bit_wr)     mask[bit_ch] <= bit_val;
   end

   assert_mask_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (&mask));

   assert_mask_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !mclr) |=> (mask == '0));

   assert_mask_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_wr && !mclr && !clr_all && !ld) |=>
         (mask[$past(bit_ch)] == $past(bit_val)) &&
         ($countones(mask ^ $past(mask)) <= 1));

endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
   import dma_regs_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   localparam int unsigned MODE_W = BUS_W - 2,
   localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [3:0]               bus_ofs,
   input  logic [BUS_W-1:0]         bus_wdata,
   output logic [BUS_W-1:0]         bus_rdata,
   output logic [BUS_W-1:0]         ctl_cmd,
   output logic                     ctl_enable,
   output logic [NUM_CH-1:0]        chan_mask,
   output logic [NUM_CH*MODE_W-1:0] chan_mode,
   output logic [NUM_CH*ADDR_W-1:0] chan_addr,
   output logic [NUM_CH*CNT_W-1:0]  chan_count
);

   // the offset map fixes these values
   if (NUM_CH != 4) begin : g_bad_ch
      $error("dma_host_regs: the offset map holds exactly four channels");
   end
   if (ADDR_W != 2*BUS_W || CNT_W != 2*BUS_W) begin : g_bad_w
      $error("dma_host_regs: address and count must be two bus bytes wide");
   end
   if (BUS_W < 8) begin : g_bad_bus
      $error("dma_host_regs: the command ports need at least 8 data bits");
   end

   strobes_t st;
   logic     ptr_hi;
   logic [ADDR_W-1:0] addr_q [NUM_CH];
   logic [CNT_W-1:0]  cnt_q  [NUM_CH];

   dma_port_decode u_dec (
      .sel (bus_sel),
      .wr  (bus_wr),
      .rd  (bus_rd),
      .ofs (bus_ofs),
      .st  (st)
   );

   dma_byte_ptr u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st.ptr_clr | st.mclr),
      .step  (st.reg_wr | st.reg_rd),
      .hi    (ptr_hi)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_ch;
      assign sel_ch = (st.ch == CH_W'(i));
      dma_chan_regs #(
         .BUS_W  (BUS_W),
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .MODE_W (MODE_W)
      ) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .mclr     (st.mclr),
         .hi       (ptr_hi),
         .wr_addr  (st.reg_wr && sel_ch && !st.is_cnt),
         .wr_cnt   (st.reg_wr && sel_ch && st.is_cnt),
         .wdata    (bus_wdata),
         .mode_ld  (st.mode_wr && (bus_wdata[CH_W-1:0] == CH_W'(i))),
         .mode_in  (bus_wdata[BUS_W-1:2]),
         .cur_addr (addr_q[i]),
         .cur_cnt  (cnt_q[i]),
         .mode     (chan_mode[i*MODE_W +: MODE_W])
      );
      assign chan_addr[i*ADDR_W +: ADDR_W] = addr_q[i];
      assign chan_count[i*CNT_W +: CNT_W]  = cnt_q[i];
   end

   dma_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .mclr    (st.mclr),
      .bit_wr  (st.mask_bit_wr),
      .bit_ch  (bus_wdata[CH_W-1:0]),
      .bit_val (bus_wdata[2]),
      .clr_all (st.mask_clr_all),
      .ld      (st.mask_ld),
      .ld_val  (bus_wdata[NUM_CH-1:0]),
      .mask    (chan_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || st.mclr) ctl_cmd <= '0;
      else if (st.cmd_wr)    ctl_cmd <= bus_wdata;
   end

   assign ctl_enable = ~ctl_cmd[2];

   logic [ADDR_W-1:0] rd_word;
   always_comb begin
      rd_word   = st.is_cnt ? cnt_q[st.ch] : addr_q[st.ch];
      bus_rdata = '0;
      if (st.reg_rd)
         bus_rdata = ptr_hi ? rd_word[ADDR_W-1:BUS_W] : rd_word[BUS_W-1:0];
      else if (st.mask_rd)
         bus_rdata[NUM_CH-1:0] = chan_mask;
   end

   assert_master_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st.mclr |=> (ctl_cmd == '0) && !ptr_hi && (chan_addr == '0) && (chan_count == '0));

   assert_no_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> $stable(ctl_cmd) && $stable(chan_mask) && $stable(ptr_hi)
                   && $stable(chan_addr) && $stable(chan_count) && $stable(chan_mode));

   assert_cmd_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st.cmd_wr |=> (ctl_cmd == $past(bus_wdata)));

endmodule

// File: tb/test_dma_host_regs.sv
`timescale 1ns/1ps
module test_dma_host_regs;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_ofs = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata, ctl_cmd;
   logic        ctl_enable;
   logic [3:0]  chan_mask;
   logic [23:0] chan_mode;
   logic [63:0] chan_addr, chan_count;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   dma_host_regs i_dma_host_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_ofs(bus_ofs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ctl_cmd(ctl_cmd), .ctl_enable(ctl_enable), .chan_mask(chan_mask),
      .chan_mode(chan_mode), .chan_addr(chan_addr), .chan_count(chan_count)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one bus cycle, held across one rising edge
   task automatic bus_op(input logic s, input logic w, input logic r,
                         input logic [3:0] o, input logic [7:0] d);
      @(posedge clk); #1;
      bus_sel = s; bus_wr = w; bus_rd = r; bus_ofs = o; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] o, input logic [7:0] d);
      bus_op(1'b1, 1'b1, 1'b0, o, d);
   endtask

   task automatic rd_expect(input logic [3:0] o, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_op(1'b1, 1'b0, 1'b1, o, 8'h00);
   endtask

   // monitor: compares read data mid-cycle against the scoreboard
   always @(negedge clk) begin
      if (bus_sel && bus_rd && !bus_wr) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2 unexpected read actual=%0h expected=none", bus_rdata);
         end else begin
            string t;
            logic [7:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {24'h0, bus_rdata}, {24'h0, e});
         end
      end
   end

   function automatic logic [15:0] addr_of(input int c);
      return chan_addr[c*16 +: 16];
   endfunction
   function automatic logic [15:0] cnt_of(input int c);
      return chan_count[c*16 +: 16];
   endfunction
   function automatic logic [5:0] mode_of(input int c);
      return chan_mode[c*6 +: 6];
   endfunction

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      chk("R1 mask", chan_mask, 4'hF);
      chk("R1 cmd", ctl_cmd, 0);
      chk("R1 enable", ctl_enable, 1);
      chk("R1 addr", chan_addr[31:0] | chan_addr[63:32], 0);
      chk("R1 count", chan_count[31:0] | chan_count[63:32], 0);
      chk("R1 mode", chan_mode, 0);
      rd_expect(4'h0, 8'h00, "R1 read lo");
      rd_expect(4'h0, 8'h00, "R1 read hi");

      // R2 byte-serial address write and readback
      wr(4'h2, 8'h34);
      wr(4'h2, 8'h12);
      chk("R2 ch1 addr", addr_of(1), 16'h1234);
      rd_expect(4'h2, 8'h34, "R2 read lo");
      rd_expect(4'h2, 8'h12, "R2 read hi");

      // R3 count write isolated to one register
      wr(4'h5, 8'hCD);
      wr(4'h5, 8'hAB);
      chk("R3 ch2 count", cnt_of(2), 16'hABCD);
      chk("R3 ch2 addr", addr_of(2), 0);
      chk("R3 ch1 count", cnt_of(1), 0);
      chk("R3 ch1 addr", addr_of(1), 16'h1234);
      chk("R3 ch0 addr", addr_of(0), 0);
      rd_expect(4'h5, 8'hCD, "R3 read cnt lo");
      rd_expect(4'h5, 8'hAB, "R3 read cnt hi");

      // R4 pointer clear from the high state
      wr(4'h0, 8'h55);
      wr(4'hC, 8'hA7);
      wr(4'h0, 8'h66);
      chk("R4 ch0 addr", addr_of(0), 16'h0066);
      wr(4'hC, 8'h00);

      // R5 mode loads
      wr(4'hB, 8'h49);
      wr(4'hB, 8'hC0);
      chk("R5 ch1 mode", mode_of(1), 6'h12);
      chk("R5 ch1 type field", mode_of(1) & 6'h03, 2'b10);
      chk("R5 ch1 mode field", mode_of(1) >> 4, 2'b01);
      chk("R5 ch0 mode", mode_of(0), 6'h30);
      chk("R5 ch2 mode", mode_of(2), 0);

      // R6 single mask bit
      wr(4'hA, 8'h01);
      chk("R6 unmask ch1", chan_mask, 4'hD);
      wr(4'hA, 8'h06);
      chk("R6 mask ch2", chan_mask, 4'hD);
      wr(4'hA, 8'h02);
      chk("R6 unmask ch2", chan_mask, 4'h9);
      rd_expect(4'hF, 8'h09, "R8 read mask");

      // R7 clear all masks
      wr(4'hE, 8'h5A);
      chk("R7 mask", chan_mask, 4'h0);
      rd_expect(4'hF, 8'h00, "R7 read mask");

      // R8 whole mask load
      wr(4'hF, 8'hFA);
      chk("R8 mask", chan_mask, 4'hA);
      rd_expect(4'hF, 8'h0A, "R8 read mask");

      // R9 command and enable
      wr(4'h8, 8'h04);
      chk("R9 cmd", ctl_cmd, 8'h04);
      chk("R9 disabled", ctl_enable, 0);
      wr(4'h8, 8'h00);
      chk("R9 enabled", ctl_enable, 1);

      // R11 register-port reads return zero and keep the pointer
      wr(4'hC, 8'h00);
      rd_expect(4'h8, 8'h00, "R11 read status");
      rd_expect(4'h9, 8'h00, "R11 read 9");
      rd_expect(4'hD, 8'h00, "R11 read D");
      rd_expect(4'h2, 8'h34, "R11 pointer held lo");
      rd_expect(4'h2, 8'h12, "R11 pointer then hi");

      // R12 deselected accesses
      bus_op(1'b0, 1'b1, 1'b0, 4'hE, 8'h00);
      bus_op(1'b0, 1'b1, 1'b0, 4'h2, 8'hEE);
      chk("R12 mask", chan_mask, 4'hA);
      chk("R12 ch1 addr", addr_of(1), 16'h1234);
      rd_expect(4'h2, 8'h34, "R12 pointer lo");
      wr(4'hC, 8'h00);

      // R10 master clear
      wr(4'h8, 8'h04);
      wr(4'h0, 8'h11);
      wr(4'hD, 8'h00);
      chk("R10 mask", chan_mask, 4'hF);
      chk("R10 cmd", ctl_cmd, 0);
      chk("R10 enable", ctl_enable, 1);
      chk("R10 addr", chan_addr[31:0] | chan_addr[63:32], 0);
      chk("R10 count", chan_count[31:0] | chan_count[63:32], 0);
      chk("R10 mode", chan_mode, 0);
      wr(4'h0, 8'h77);
      chk("R10 pointer lo", addr_of(0), 16'h0077);

      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R2 reads pending actual=%0d expected=0", exp_q.size());
      end
      finish_run();
   end

endmodule